// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block sits between a synchronous host and an external asynchronous static memory of 2048 bytes, reached through 11 address lines and an 8-bit shared three-state data bus. The memory has three active-low strobes: chip select, write strobe and output enable. The host asks for one access per handshake by raising `req` with `req_we`, `req_addr` and `req_wdata` while `ready` is high. The controller then runs a fixed sequence of strobes whose every phase length comes from a nanosecond figure. Each figure is converted to whole clock cycles when the design is elaborated. Reads end with the captured byte on `rdata` and a one-cycle `rdata_valid` pulse.

Three timing sets are built in and one is chosen by `SPEED_GRADE`. Index 0 gives a 70 ns cycle, index 1 gives 150 ns and index 2 gives 200 ns. `CLK_PERIOD_NS` states the host clock period. `RD_ACCESS_NS` sets how long chip select and output enable stay low on a read.

The sequencer has six named states:
- IDLE: ready, all strobes high.
- W_SETUP: chip select low, bus driven, write strobe still high.
- W_PULSE: write strobe low.
- W_HOLD: strobes high, bus still driven.
- R_ACCESS: chip select and output enable low.
- RECOVER: everything released.

Its transitions are:
- IDLE to W_SETUP on an accepted write.
- IDLE to R_ACCESS on an accepted read.
- W_SETUP to W_PULSE after one cycle.
- W_PULSE to W_HOLD when the pulse count ends.
- W_HOLD to RECOVER when the hold count ends.
- R_ACCESS to RECOVER when the access count ends, capturing the bus.
- RECOVER to IDLE when the recovery count ends.

Top module: `sram_ctl_top`

## Requirements
- R1: During and right after reset, `ready` is 1, all three strobes are 1, `rdata_valid` is 0 and the controller does not drive `mem_dq` (it reads as high impedance).
- R2: On a write, the write strobe stays low for at least ceil(tWP/period) cycles. The strobe is low only while chip select is low. From the fall of chip select to the rise of the write strobe there are at least ceil(tAW/period) cycles. tWP is 50/90/120 ns and tAW is 60/120/140 ns for grades 0/1/2.
- R3: Write data is stable on `mem_dq` for at least ceil(tDW/period) cycles before the write strobe rises, with tDW = 30/40/60 ns. It stays driven for at least ceil(5 ns/period) cycles after the rise.
- R4: Output enable is 1 whenever the write strobe is 0. The controller drives `mem_dq` only while output enable is 1.
- R5: `mem_addr` does not change while chip select is low, nor from the write strobe's rise until the controller is ready again.
- R6: Two successive chip-select falls are at least ceil(tWC/period) cycles apart, with tWC = 70/150/200 ns.
- R7: A read holds chip select and output enable low, with the write strobe high, for ceil(RD_ACCESS_NS/period) cycles. It then presents on `rdata` the byte stored at the address and raises `rdata_valid` for exactly one cycle.
- R8: `ready` goes to 0 on the cycle after a request is accepted and stays 0 until the sequence ends. A `req` raised while `ready` is 0 is ignored: the stored byte at its address is unchanged.
- R9: Each nonzero ns limit is rounded up to whole cycles (at least one), and the set used is the one `SPEED_GRADE` selects.
- R10: Every address from 0 through 2047 reaches the memory, including both ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when `ready` is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle and able to accept |
| rdata | output | 8 | Byte captured on the last read |
| rdata_valid | output | 1 | One-cycle pulse when `rdata` is new |
| mem_addr | output | 11 | Address lines to the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | inout | 8 | Shared three-state data bus |

## Verification
A state register that jumps wrongly shows on the strobe pins in the same cycle, because every strobe decodes directly from the state. A wrong pulse or hold counter shows as a write-strobe low run or a bus-driven run of the wrong length. That error is visible at the write strobe's rise, within one access. A bad recovery count shortens the spacing of chip-select falls, so the next access reveals it. A wrong capture cycle returns a stale or undriven byte at the `rdata_valid` pulse of the same read.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_SETUP,
        ST_W_PULSE,
        ST_W_HOLD,
        ST_R_ACCESS,
        ST_RECOVER
    } seq_state_t;

    typedef enum int {
        LIM_CYCLE,
        LIM_PULSE,
        LIM_DSETUP,
        LIM_DHOLD,
        LIM_ARECOV,
        LIM_ASETUP
    } limit_t;

    // Minimum times in ns for grades 0, 1 and 2
    function automatic int limit_ns(int grade, limit_t which);
        int g;
        g = (grade < 0) ? 0 : ((grade > 2) ? 2 : grade);
        unique case (which)
            LIM_CYCLE:  return (g == 0) ? 70 : ((g == 1) ? 150 : 200);
            LIM_PULSE:  return (g == 0) ? 50 : ((g == 1) ? 90  : 120);
            LIM_DSETUP: return (g == 0) ? 30 : ((g == 1) ? 40  : 60);
            LIM_DHOLD:  return 5;
            LIM_ARECOV: return (g == 0) ? 0  : 10;
            default:    return (g == 0) ? 60 : ((g == 1) ? 120 : 140);
        endcase
    endfunction

    function automatic int ns_to_cyc(int ns, int period_ns);
        return (ns <= 0) ? 0 : (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 5,
    parameter int SPEED_GRADE   = 0,
    parameter int RD_ACCESS_NS  = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_we,
    output logic ready,
    output logic load,
    output logic capture,
    output logic rdata_valid,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic bus_drive
);
    localparam int WC_CYC  = ns_to_cyc(limit_ns(SPEED_GRADE, LIM_CYCLE),  CLK_PERIOD_NS);
    localparam int WPM_CYC = ns_to_cyc(limit_ns(SPEED_GRADE, LIM_PULSE),  CLK_PERIOD_NS);
    localparam int DW_CYC  = ns_to_cyc(limit_ns(SPEED_GRADE, LIM_DSETUP), CLK_PERIOD_NS);
    localparam int DH_CYC  = ns_to_cyc(limit_ns(SPEED_GRADE, LIM_DHOLD),  CLK_PERIOD_NS);
    localparam int WR_CYC  = ns_to_cyc(limit_ns(SPEED_GRADE, LIM_ARECOV), CLK_PERIOD_NS);
    localparam int AW_CYC  = ns_to_cyc(limit_ns(SPEED_GRADE, LIM_ASETUP), CLK_PERIOD_NS);
    // Setup state gives one cycle of data and address before the strobe falls
    localparam int WP_LEN  = imax(imax(WPM_CYC, DW_CYC - 1), imax(AW_CYC - 1, 1));
    localparam int HD_LEN  = imax(imax(DH_CYC, WR_CYC), 1);
    localparam int WREC    = imax(1, WC_CYC - 1 - WP_LEN - HD_LEN);
    localparam int RD_LEN  = imax(1, ns_to_cyc(RD_ACCESS_NS, CLK_PERIOD_NS));
    localparam int RREC    = imax(1, WC_CYC - RD_LEN - 1);
    localparam int MAXLEN  = imax(imax(WP_LEN, HD_LEN), imax(imax(WREC, RD_LEN), RREC));
    localparam int CNT_W   = $clog2(MAXLEN + 1) + 1;

    seq_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             wr_q;
    logic             rec_last;

    assign rec_last = wr_q ? (cnt == CNT_W'(WREC - 1)) : (cnt == CNT_W'(RREC - 1));
    assign load     = (state == ST_IDLE) && req;
    assign capture  = (state == ST_R_ACCESS) && (cnt == CNT_W'(RD_LEN - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req) state_nx = req_we ? ST_W_SETUP : ST_R_ACCESS;
            ST_W_SETUP:  state_nx = ST_W_PULSE;
            ST_W_PULSE:  if (cnt == CNT_W'(WP_LEN - 1)) state_nx = ST_W_HOLD;
            ST_W_HOLD:   if (cnt == CNT_W'(HD_LEN - 1)) state_nx = ST_RECOVER;
            ST_R_ACCESS: if (capture) state_nx = ST_RECOVER;
            ST_RECOVER:  if (rec_last) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            wr_q        <= 1'b0;
            rdata_valid <= 1'b0;
        end else begin
            state       <= state_nx;
            cnt         <= (state_nx != state) ? '0 : cnt + 1'b1;
            rdata_valid <= capture;
            if (load) wr_q <= req_we;
        end
    end

    always_comb begin
        ready     = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        bus_drive = 1'b0;
        unique case (state)
            ST_IDLE:     ready = 1'b1;
            ST_W_SETUP:  begin mem_ce_n = 1'b0; bus_drive = 1'b1; end
            ST_W_PULSE:  begin mem_ce_n = 1'b0; mem_we_n = 1'b0; bus_drive = 1'b1; end
            ST_W_HOLD:   bus_drive = 1'b1;
            ST_R_ACCESS: begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
            default:     ;
        endcase
    end

    // Independent run counter for the strobe width check
    logic [CNT_W-1:0] we_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)         we_low_run <= '0;
        else if (!mem_we_n) we_low_run <= we_low_run + 1'b1;
        else                we_low_run <= '0;
    end

    assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_run >= CNT_W'(WPM_CYC)));
    assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);
    assert_oe_high_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> mem_oe_n);
    assert_drive_after_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> bus_drive);
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);
    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);
endmodule

// File: rtl/sram_ctl_top.sv
module sram_ctl_top #(
    parameter int CLK_PERIOD_NS = 5,
    parameter int SPEED_GRADE   = 0,
    parameter int RD_ACCESS_NS  = 70,
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    logic              load, capture, bus_drive;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    sram_ctl_fsm #(
        .CLK_PERIOD_NS(CLK_PERIOD_NS),
        .SPEED_GRADE  (SPEED_GRADE),
        .RD_ACCESS_NS (RD_ACCESS_NS)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .ready      (ready),
        .load       (load),
        .capture    (capture),
        .rdata_valid(rdata_valid),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .bus_drive  (bus_drive)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (load) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata <= mem_dq;
        end
    end

    assign mem_addr = addr_q;
    assign mem_dq   = bus_drive ? wdata_q : {DATA_W{1'bz}};

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(mem_addr));
    assert_wdata_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive && $past(bus_drive)) |-> $stable(mem_dq));
endmodule

// File: tb/sram_ctl_top_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_top_tb_top;
    localparam int PER = 5;
    localparam int GRADE = 0;
    localparam int RD_NS = 70;

    function automatic int cyc(int ns);
        return (ns <= 0) ? 0 : (ns + PER - 1) / PER;
    endfunction
    localparam int WC_REQ = cyc(GRADE == 0 ? 70 : GRADE == 1 ? 150 : 200);
    localparam int WP_REQ = cyc(GRADE == 0 ? 50 : GRADE == 1 ? 90 : 120);
    localparam int DW_REQ = cyc(GRADE == 0 ? 30 : GRADE == 1 ? 40 : 60);
    localparam int AW_REQ = cyc(GRADE == 0 ? 60 : GRADE == 1 ? 120 : 140);
    localparam int DH_REQ = cyc(5);
    localparam int RD_REQ = cyc(RD_NS);

    logic clk = 0, rst_n = 0, req = 0, req_we = 0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic ready, rdata_valid, mem_ce_n, mem_we_n, mem_oe_n;
    logic [7:0]  rdata;
    logic [10:0] mem_addr;
    wire  [7:0]  mem_dq;

    sram_ctl_top #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(GRADE), .RD_ACCESS_NS(RD_NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .rdata_valid(rdata_valid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq(mem_dq));

    always #(PER / 2.0) clk = ~clk;

    // Memory model
    logic [7:0] mem [2048];
    assign mem_dq = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr] : 8'hzz;

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor, sampled mid-cycle
    int cyc_n = 0, we_run = 0, ce_run = 0, oe_run = 0, dq_run = 0, hold_run = 0;
    int last_ce_fall = -1000, writes_seen = 0;
    bit pend = 0, in_hold = 0, prev_ce_low = 0, mon_on = 0;
    logic [10:0] pa, prev_addr;
    logic [7:0]  pd, prev_dq;
    always @(negedge clk) begin
        cyc_n++;
        if (mon_on) begin
            if (!mem_ce_n && !prev_ce_low) begin
                check(cyc_n - last_ce_fall >= WC_REQ, "R6 ce spacing", cyc_n - last_ce_fall, WC_REQ);
                last_ce_fall = cyc_n;
            end
            if (!mem_ce_n && prev_ce_low)
                check(mem_addr == prev_addr, "R5 addr stable", mem_addr, prev_addr);
            if (!mem_we_n) check(mem_oe_n === 1'b1, "R4 oe high in write", mem_oe_n, 1);
            ce_run = !mem_ce_n ? ce_run + 1 : 0;
            dq_run = (mem_dq === prev_dq && !$isunknown(mem_dq)) ? dq_run + 1 : (!$isunknown(mem_dq) ? 1 : 0);
            if (!mem_ce_n && !mem_we_n) begin
                pend = 1; pa = mem_addr; pd = mem_dq; we_run++;
            end else if (pend) begin
                mem[pa] = pd; pend = 0; writes_seen++;
                check(we_run >= WP_REQ, "R2 strobe width", we_run, WP_REQ);
                check(prev_ce_low && ce_run == 0, "R2 strobe within ce", ce_run, 0);
                in_hold = 1; hold_run = 0;
            end
            if (mem_we_n) we_run = 0;
            if (in_hold) begin
                if (mem_dq === pd) hold_run++;
                else begin
                    check(hold_run >= DH_REQ, "R3 data hold", hold_run, DH_REQ);
                    in_hold = 0;
                end
            end
            if (!mem_oe_n) begin
                oe_run++;
                check(mem_we_n === 1'b1 && !mem_ce_n, "R7 read strobes", mem_we_n, 1);
            end else if (oe_run != 0) begin
                check(oe_run == RD_REQ, "R7 access length", oe_run, RD_REQ);
                oe_run = 0;
            end
        end
        prev_ce_low = !mem_ce_n;
        prev_addr = mem_addr;
        prev_dq = mem_dq;
    end

    // Setup checks done just before the strobe rises: count at the last low sample
    int ce_low_at_rise = 0, dq_at_rise = 0;
    always @(negedge clk) begin
        #1;
        if (mon_on && !mem_we_n && dut_i.mem_we_n === 1'b0) begin
            ce_low_at_rise = ce_run;
            dq_at_rise = dq_run;
        end
    end
    always @(posedge mem_we_n) if (mon_on && rst_n) begin
        check(ce_low_at_rise >= AW_REQ, "R2 addr to strobe rise", ce_low_at_rise, AW_REQ);
        check(dq_at_rise >= DW_REQ, "R3 data setup", dq_at_rise, DW_REQ);
    end

    task automatic wait_ready();
        int n = 0;
        @(negedge clk);
        while (!ready && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic issue(input bit we, input logic [10:0] a, input logic [7:0] d);
        wait_ready();
        req = 1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 0;
        check(ready === 1'b0, "R8 busy after accept", ready, 0);
    endtask

    task automatic read_expect(input logic [10:0] a, input logic [7:0] exp, input string tag);
        int n = 0;
        issue(0, a, 8'h00);
        while (!rdata_valid && n < 1000) begin @(negedge clk); n++; end
        check(rdata_valid && rdata == exp, tag, rdata, exp);
        @(negedge clk);
        check(rdata_valid === 1'b0, "R7 valid one cycle", rdata_valid, 0);
    endtask

    typedef struct packed { logic we; logic [10:0] addr; logic [7:0] data; } vec_t;
    localparam vec_t VECS [10] = '{
        '{1'b1, 11'd0,    8'hA5}, '{1'b1, 11'd2047, 8'h3C}, '{1'b1, 11'd1, 8'hFF},
        '{1'b1, 11'd1024, 8'h00}, '{1'b0, 11'd0,    8'hA5}, '{1'b0, 11'd2047, 8'h3C},
        '{1'b1, 11'd0,    8'h5A}, '{1'b0, 11'd1,    8'hFF}, '{1'b0, 11'd0, 8'h5A},
        '{1'b0, 11'd1024, 8'h00}};

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'h11;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ready === 1'b1, "R1 ready in reset", ready, 1);
        check({mem_ce_n, mem_we_n, mem_oe_n} === 3'b111, "R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        check(mem_dq === 8'hzz, "R1 bus released", mem_dq, 0);
        rst_n = 1;
        @(negedge clk);
        check(ready === 1'b1 && rdata_valid === 1'b0, "R1 after reset", ready, 1);
        mon_on = 1;
        // Table walk: R9 rounding via the required cycle counts, R10 range ends
        foreach (VECS[i]) begin
            if (VECS[i].we) issue(1, VECS[i].addr, VECS[i].data);
            else read_expect(VECS[i].addr, VECS[i].data, "R10 R7 read data");
        end
        // R8: request while busy is ignored
        issue(1, 11'd5, 8'h55);
        req = 1; req_we = 1; req_addr = 11'd5; req_wdata = 8'hAA;
        @(negedge clk);
        req = 0;
        read_expect(11'd5, 8'h55, "R8 busy request ignored");
        // Back-to-back requests held high: R6 spacing checked by monitor
        wait_ready();
        req = 1; req_we = 1; req_addr = 11'd7; req_wdata = 8'h77;
        @(negedge clk);
        req_addr = 11'd8; req_wdata = 8'h88;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 0;
        read_expect(11'd7, 8'h77, "R6 first of pair");
        read_expect(11'd8, 8'h88, "R6 second of pair");
        read_expect(11'd2046, 8'h11, "R10 untouched byte");
        check(writes_seen == 8, "R8 write count", writes_seen, 8);
        repeat (20) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule